// File: doc/BRIEF.md
# Endpoint-Zero Control Stage Tracker

This block follows a USB device controller's endpoint zero through each control transfer. The packet engine reports events as single-cycle pulses: a SETUP has arrived (with its direction and requested length), an IN packet has been handed to the bus, an IN packet has been acknowledged, an OUT packet has landed, firmware asks for a stall, or the bus was reset. The block answers with the current stage code and a stall-handshake flag.

It also holds a six-byte response store. For a device status request it preloads a two-byte reply and streams it out during the IN data stage. For a link-latency (SET_SEL style) request it takes up to six payload bytes from an OUT stream during the OUT data stage. The stored bytes are always visible on a flat output bus.

Both byte streams use valid/ready. A byte moves on a clock edge where valid and ready are both high. While `tx_valid` is high and `tx_ready` is low, the outgoing byte is held steady. `rx_ready` falls once the store is full, and any bytes offered after that are not taken. Request decoding, packet serialisation and the PHY are outside the block.

Top module: `ep0_ctrl_tracker`

## Requirements
- R1: After reset, `state` is 1 (waiting for SETUP), `stall_hs` is 0, `tx_valid` is 0, `rx_ready` is 0 and `sel_buf` is all zero.
- R2: The stage codes are SETUP=1, IN data=2, OUT data=3, final-IN wait=4 and STALL=5. A SETUP with length 0 leaves the machine in 1. A nonzero length moves it to 2 when `setup_dir_in`=1 (device-to-host) and to 3 otherwise.
- R3: In stage 2, each `in_sent` pulse adds `in_bytes` to a running count. The pulse moves the machine to 4 when the count reaches the requested length or when `in_bytes` is below MAXP (64). Otherwise the machine stays in 2.
- R4: In stage 4, `in_ack` returns the machine to 1. `in_sent` and `out_rcv` have no effect there.
- R5: In stage 3, each `out_rcv` pulse adds `out_bytes` to a running count. The machine returns to 1 once that count reaches the requested length.
- R6: `stall_req` moves the machine to 5 from any stage. `stall_hs` is 1 exactly while the stage is 5.
- R7: Stage 5 is left only by a SETUP or a bus reset. `in_ack`, `in_sent` and `out_rcv` leave it in 5.
- R8: `bus_reset` forces stage 1 from any stage, clears the byte counts and the stream positions, and takes priority over every other input in the same cycle.
- R9: A SETUP with `setup_kind`=1 (status request) loads byte 0 of the store with {6'b0, `wake_en`, `self_pwr`} and byte 1 with 0. In stage 2, `tx_valid` then presents bytes 0 and up in order, min(length, 2) bytes in all. Each byte is held stable until it is accepted.
- R10: For a SETUP with `setup_kind`=2 (latency payload), `rx_ready` is high in stage 3 until six bytes have been accepted. Accepted byte i appears in `sel_buf[8*i+7:8*i]`. In every other case `rx_ready` is 0 and `sel_buf` does not change.
- R11: A SETUP in any stage restarts the transfer, clears the counts, and takes priority over `stall_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_reset | input | 1 | Bus reset pulse |
| setup_evt | input | 1 | SETUP received pulse |
| setup_dir_in | input | 1 | 1 = device-to-host data stage |
| setup_len | input | LEN_W | Requested data length |
| setup_kind | input | 2 | 0 other, 1 status request, 2 latency payload |
| in_sent | input | 1 | IN packet handed to the bus |
| in_bytes | input | PKT_W | Byte count of that IN packet |
| in_ack | input | 1 | IN packet completion |
| out_rcv | input | 1 | OUT packet received |
| out_bytes | input | PKT_W | Byte count of that OUT packet |
| stall_req | input | 1 | Stall request |
| self_pwr | input | 1 | Self-powered status bit |
| wake_en | input | 1 | Remote-wakeup enabled bit |
| tx_valid | output | 1 | Response byte available |
| tx_ready | input | 1 | Consumer takes the response byte |
| tx_data | output | 8 | Response byte |
| rx_valid | input | 1 | Payload byte offered |
| rx_ready | output | 1 | Store accepts a payload byte |
| rx_data | input | 8 | Payload byte |
| state | output | 3 | Current stage code |
| stall_hs | output | 1 | Answer with a stall handshake |
| sel_buf | output | 8*BUF_BYTES | Flat view of the response store |

## Verification
The bench targets five corner cases.

- A length that is an exact multiple of 64. A design that treats only short packets as final would wait forever in stage 2.
- A short packet that ends the IN stage before the full length has been sent. A design that compares counts only would miss it.
- Acknowledgements and packets that arrive during stall or final-IN wait. A design that is too permissive would leave those stages early.
- Collisions in the same cycle: bus reset with SETUP, and SETUP with stall. A wrong priority would land in the wrong stage.
- A consumer that stalls the response stream, and a payload source that offers a seventh byte. A design that got these wrong would skip or change the response byte, or overwrite the store.

// File: rtl/ep0_trk_pkg.sv
package ep0_trk_pkg;
  typedef enum logic [2:0] {
    ST_SETUP  = 3'd1,
    ST_IN     = 3'd2,
    ST_OUT    = 3'd3,
    ST_IN_END = 3'd4,
    ST_STALL  = 3'd5
  } ep0_stage_e;

  typedef enum logic [1:0] {
    RQ_OTHER  = 2'd0,
    RQ_STATUS = 2'd1,
    RQ_SEL    = 2'd2
  } ep0_req_e;

  localparam int STATUS_LEN = 2;
endpackage

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_trk_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MAXP  = 64,
  parameter int PKT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             setup_evt,
  input  logic             setup_dir_in,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             in_sent,
  input  logic [PKT_W-1:0] in_bytes,
  input  logic             in_ack,
  input  logic             out_rcv,
  input  logic [PKT_W-1:0] out_bytes,
  input  logic             stall_req,
  output ep0_stage_e       stage_o
);
  localparam int CNT_W = LEN_W + 1;

  ep0_stage_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] sum_in, sum_out, len_ext;
  logic             in_last, out_done;

  assign len_ext  = {1'b0, len_q};
  assign sum_in   = cnt_q + CNT_W'(in_bytes);
  assign sum_out  = cnt_q + CNT_W'(out_bytes);
  assign in_last  = (sum_in >= len_ext) || (in_bytes < PKT_W'(MAXP));
  assign out_done = (sum_out >= len_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SETUP;
      cnt_q <= '0;
      len_q <= '0;
    end else if (bus_reset) begin
      st_q  <= ST_SETUP;
      cnt_q <= '0;
    end else if (setup_evt) begin
      cnt_q <= '0;
      len_q <= setup_len;
      if (setup_len == '0) st_q <= ST_SETUP;
      else if (setup_dir_in) st_q <= ST_IN;
      else st_q <= ST_OUT;
    end else if (stall_req) begin
      st_q <= ST_STALL;
    end else begin
      unique case (st_q)
        ST_IN: if (in_sent) begin
          cnt_q <= sum_in;
          if (in_last) st_q <= ST_IN_END;
        end
        ST_IN_END: if (in_ack) st_q <= ST_SETUP;
        ST_OUT: if (out_rcv) begin
          cnt_q <= sum_out;
          if (out_done) st_q <= ST_SETUP;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  assign stage_o = st_q;
endmodule

// File: rtl/ep0_resp_store.sv
module ep0_resp_store
  import ep0_trk_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_reset,
  input  logic                   setup_evt,
  input  logic [1:0]             setup_kind,
  input  logic [LEN_W-1:0]       setup_len,
  input  logic                   self_pwr,
  input  logic                   wake_en,
  input  ep0_stage_e             stage,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  input  logic [7:0]             rx_data,
  output logic [8*BUF_BYTES-1:0] sel_buf
);
  localparam int IDX_W = $clog2(BUF_BYTES + 1);

  ep0_req_e         kind_q;
  logic [IDX_W-1:0] rd_q, wr_q, serve_q;
  logic [7:0]       mem [BUF_BYTES];
  logic             tx_fire, rx_fire, is_status;

  assign is_status = (ep0_req_e'(setup_kind) == RQ_STATUS);
  assign tx_valid  = (stage == ST_IN) && (kind_q == RQ_STATUS) && (rd_q < serve_q);
  assign rx_ready  = (stage == ST_OUT) && (kind_q == RQ_SEL) && (wr_q < IDX_W'(BUF_BYTES));
  assign tx_fire   = tx_valid && tx_ready && !bus_reset && !setup_evt;
  assign rx_fire   = rx_valid && rx_ready && !bus_reset && !setup_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= RQ_OTHER;
      rd_q    <= '0;
      wr_q    <= '0;
      serve_q <= '0;
    end else if (bus_reset) begin
      kind_q <= RQ_OTHER;
      rd_q   <= '0;
      wr_q   <= '0;
    end else if (setup_evt) begin
      kind_q  <= ep0_req_e'(setup_kind);
      rd_q    <= '0;
      wr_q    <= '0;
      serve_q <= (setup_len < LEN_W'(STATUS_LEN)) ? IDX_W'(setup_len) : IDX_W'(STATUS_LEN);
    end else begin
      if (tx_fire) rd_q <= rd_q + 1'b1;
      if (rx_fire) wr_q <= wr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (setup_evt && !bus_reset && is_status && g < STATUS_LEN) begin
        mem[g] <= (g == 0) ? {6'b0, wake_en, self_pwr} : 8'h00;
      end else if (rx_fire && wr_q == IDX_W'(g)) begin
        mem[g] <= rx_data;
      end
    end
    assign sel_buf[8*g +: 8] = mem[g];
  end

  always_comb begin
    tx_data = 8'h00;
    for (int i = 0; i < BUF_BYTES; i++)
      if (rd_q == IDX_W'(i)) tx_data = mem[i];
  end
endmodule

// File: rtl/ep0_ctrl_tracker.sv
module ep0_ctrl_tracker
  import ep0_trk_pkg::*;
#(
  parameter int  LEN_W     = 16,
  parameter int  MAXP      = 64,
  parameter int  BUF_BYTES = 6,
  localparam int PKT_W     = $clog2(MAXP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_reset,
  input  logic                   setup_evt,
  input  logic                   setup_dir_in,
  input  logic [LEN_W-1:0]       setup_len,
  input  logic [1:0]             setup_kind,
  input  logic                   in_sent,
  input  logic [PKT_W-1:0]       in_bytes,
  input  logic                   in_ack,
  input  logic                   out_rcv,
  input  logic [PKT_W-1:0]       out_bytes,
  input  logic                   stall_req,
  input  logic                   self_pwr,
  input  logic                   wake_en,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  input  logic [7:0]             rx_data,
  output logic [2:0]             state,
  output logic                   stall_hs,
  output logic [8*BUF_BYTES-1:0] sel_buf
);
  ep0_stage_e stage;

  ep0_stage_fsm #(.LEN_W(LEN_W), .MAXP(MAXP), .PKT_W(PKT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .setup_evt(setup_evt),
    .setup_dir_in(setup_dir_in), .setup_len(setup_len), .in_sent(in_sent),
    .in_bytes(in_bytes), .in_ack(in_ack), .out_rcv(out_rcv), .out_bytes(out_bytes),
    .stall_req(stall_req), .stage_o(stage)
  );

  ep0_resp_store #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .setup_evt(setup_evt),
    .setup_kind(setup_kind), .setup_len(setup_len), .self_pwr(self_pwr),
    .wake_en(wake_en), .stage(stage), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sel_buf(sel_buf)
  );

  assign state    = stage;
  assign stall_hs = (stage == ST_STALL);
endmodule

// File: rtl/ep0_ctrl_tracker_chk.sv
module ep0_ctrl_tracker_chk #(
  parameter int LEN_W = 16,
  parameter int PKT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_reset,
  input logic             setup_evt,
  input logic             setup_dir_in,
  input logic [LEN_W-1:0] setup_len,
  input logic             stall_req,
  input logic             in_ack,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rx_ready,
  input logic [2:0]       state,
  input logic             stall_hs
);
  a_r8_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> state == 3'd1);

  a_r2_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt && !bus_reset && setup_len == '0 |=> state == 3'd1);

  a_r2_direction: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt && !bus_reset && setup_len != '0 |=>
      state == ($past(setup_dir_in) ? 3'd2 : 3'd3));

  a_r6_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req && !setup_evt && !bus_reset |=> state == 3'd5 && stall_hs);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd5 && !setup_evt && !bus_reset |=> state == 3'd5);

  a_r4_final_wait: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 && !in_ack && !setup_evt && !bus_reset && !stall_req |=> state == 3'd4);

  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !setup_evt && !bus_reset && !stall_req |=>
      tx_valid && $stable(tx_data));

  a_r10_rx_stage: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> state == 3'd3);
endmodule

bind ep0_ctrl_tracker ep0_ctrl_tracker_chk #(.LEN_W(LEN_W), .PKT_W(PKT_W)) u_chk (.*);

// File: tb/ep0_ctrl_tracker_tb.sv
module ep0_ctrl_tracker_tb;
  localparam int LW = 16, MP = 64, NB = 6, PW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, bus_reset = 0, setup_evt = 0, setup_dir_in = 0;
  logic [LW-1:0] setup_len = '0;
  logic [1:0] setup_kind = '0;
  logic in_sent = 0, in_ack = 0, out_rcv = 0, stall_req = 0;
  logic [PW-1:0] in_bytes = '0, out_bytes = '0;
  logic self_pwr = 0, wake_en = 0, tx_ready = 0, rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic tx_valid, rx_ready, stall_hs;
  logic [7:0] tx_data;
  logic [2:0] state;
  logic [8*NB-1:0] sel_buf;

  ep0_ctrl_tracker u_dut (.*);

  int n_chk = 0, n_fail = 0, cycles = 0;
  string tag = "R1";
  int m_st = 1, m_cnt = 0, m_len = 0, m_kind = 0, m_rd = 0, m_wr = 0, m_slen = 0;
  int m_buf[NB] = '{default: 0};

  function automatic void chk(string t, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endfunction

  function automatic void model_step();
    bit txv = (m_st == 2 && m_kind == 1 && m_rd < m_slen);
    bit rxr = (m_st == 3 && m_kind == 2 && m_wr < NB);
    if (bus_reset) begin
      m_st = 1; m_cnt = 0; m_kind = 0; m_rd = 0; m_wr = 0;
    end else if (setup_evt) begin
      m_cnt = 0; m_len = setup_len; m_kind = setup_kind; m_rd = 0; m_wr = 0;
      m_slen = (setup_len < 2) ? setup_len : 2;
      m_st = (setup_len == 0) ? 1 : (setup_dir_in ? 2 : 3);
      if (setup_kind == 1) begin m_buf[0] = {wake_en, self_pwr}; m_buf[1] = 0; end
    end else begin
      if (txv && tx_ready) m_rd++;
      if (rxr && rx_valid) begin m_buf[m_wr] = rx_data; m_wr++; end
      if (stall_req) m_st = 5;
      else case (m_st)
        2: if (in_sent) begin
             m_cnt += in_bytes;
             if (m_cnt >= m_len || in_bytes < MP) m_st = 4;
           end
        4: if (in_ack) m_st = 1;
        3: if (out_rcv) begin
             m_cnt += out_bytes;
             if (m_cnt >= m_len) m_st = 1;
           end
        default: ;
      endcase
    end
  endfunction

  function automatic void compare();
    logic [8*NB-1:0] eb;
    bit txv = (m_st == 2 && m_kind == 1 && m_rd < m_slen);
    bit rxr = (m_st == 3 && m_kind == 2 && m_wr < NB);
    for (int i = 0; i < NB; i++) eb[8*i +: 8] = m_buf[i][7:0];
    chk(tag, state, m_st, "state");
    chk(tag, stall_hs, m_st == 5, "stall_hs");
    chk(tag, tx_valid, txv, "tx_valid");
    if (txv) chk(tag, tx_data, m_buf[m_rd], "tx_data");
    chk(tag, rx_ready, rxr, "rx_ready");
    chk(tag, sel_buf, eb, "sel_buf");
  endfunction

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic do_setup(bit din, int len, int kind);
    setup_evt = 1; setup_dir_in = din; setup_len = LW'(len); setup_kind = 2'(kind);
    cyc();
    setup_evt = 0;
  endtask

  task automatic in_pkt(int b);
    in_sent = 1; in_bytes = PW'(b); cyc(); in_sent = 0;
  endtask

  task automatic out_pkt(int b);
    out_rcv = 1; out_bytes = PW'(b); cyc(); out_rcv = 0;
  endtask

  task automatic ack();
    in_ack = 1; cyc(); in_ack = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; compare();
    chk("R1", state, 3'd1, "reset state");

    tag = "R2"; do_setup(1, 0, 0); chk("R2", state, 3'd1, "zero length");
    do_setup(0, 5, 0); chk("R2", state, 3'd3, "out dir");
    do_setup(1, 5, 0); chk("R2", state, 3'd2, "in dir");

    tag = "R9"; self_pwr = 1; wake_en = 1;
    do_setup(1, 2, 1);
    chk("R9", tx_valid, 1, "status valid");
    chk("R9", tx_data, 8'h03, "status byte0");
    cyc(); cyc();
    tx_ready = 1; cyc();
    chk("R9", tx_data, 8'h00, "status byte1");
    cyc(); tx_ready = 0;
    chk("R9", tx_valid, 0, "served two");
    tag = "R3"; in_pkt(2); chk("R3", state, 3'd4, "short final");
    tag = "R4"; out_pkt(3); in_pkt(5); chk("R4", state, 3'd4, "ignore in wait");
    ack(); chk("R4", state, 3'd1, "ack returns");

    tag = "R9"; self_pwr = 0; wake_en = 1;
    do_setup(1, 1, 1); tx_ready = 1; cyc(); cyc(); tx_ready = 0;
    chk("R9", tx_valid, 0, "one byte served");

    tag = "R3"; do_setup(1, 130, 0);
    in_pkt(64); chk("R3", state, 3'd2, "first full");
    in_pkt(64); chk("R3", state, 3'd2, "second full");
    in_pkt(2);  chk("R3", state, 3'd4, "reached");
    ack();
    do_setup(1, 128, 0); in_pkt(64); in_pkt(64);
    chk("R3", state, 3'd4, "exact multiple");
    ack();
    do_setup(1, 200, 0); in_pkt(64); in_pkt(10);
    chk("R3", state, 3'd4, "short before length");
    ack();

    tag = "R10"; do_setup(0, 6, 2);
    rx_valid = 1;
    for (int i = 0; i < 7; i++) begin rx_data = 8'hA0 + 8'(i); cyc(); end
    rx_valid = 0;
    chk("R10", sel_buf, 48'hA5A4A3A2A1A0, "payload stored, seventh ignored");
    tag = "R5"; out_pkt(6); chk("R5", state, 3'd1, "rx done");
    chk("R10", rx_ready, 0, "not ready in setup");
    rx_valid = 1; rx_data = 8'h55; cyc(); rx_valid = 0;
    chk("R10", sel_buf, 48'hA5A4A3A2A1A0, "unchanged outside stage");
    tag = "R5"; do_setup(0, 100, 0);
    out_pkt(64); chk("R5", state, 3'd3, "partial");
    out_pkt(36); chk("R5", state, 3'd1, "complete");

    tag = "R6"; do_setup(1, 10, 0); stall_req = 1; cyc(); stall_req = 0;
    chk("R6", state, 3'd5, "stall entry"); chk("R6", stall_hs, 1, "flag");
    tag = "R7"; ack(); in_pkt(3); out_pkt(3); cyc();
    chk("R7", state, 3'd5, "stall held");
    do_setup(0, 4, 0); chk("R7", state, 3'd3, "setup leaves stall");

    tag = "R11"; stall_req = 1; do_setup(1, 8, 0); stall_req = 0;
    chk("R11", state, 3'd2, "setup beats stall");
    do_setup(0, 8, 0); chk("R11", state, 3'd3, "restart mid transfer");

    tag = "R8"; out_pkt(4);
    bus_reset = 1; cyc(); bus_reset = 0;
    chk("R8", state, 3'd1, "reset from out");
    do_setup(1, 8, 0); in_pkt(8); chk("R8", state, 3'd4, "from final wait");
    bus_reset = 1; setup_evt = 1; setup_dir_in = 1; setup_len = 9; cyc();
    bus_reset = 0; setup_evt = 0;
    chk("R8", state, 3'd1, "reset beats setup");
    do_setup(1, 4, 0); stall_req = 1; cyc(); stall_req = 0;
    bus_reset = 1; cyc(); bus_reset = 0;
    chk("R8", state, 3'd1, "reset leaves stall");
    repeat (3) cyc();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule